// File: doc/BRIEF.md
# Tagged Receive Character Buffer

This block holds received serial characters between a UART receiver and a register interface. Each push from the receiver carries one 8-bit character, a framing-error flag and a break flag. A read strobe pops the oldest entry into a registered read word. That word carries the flags beside the data, plus a bit that tells software the buffer had nothing to give. Software drains the buffer by reading until that bit comes back set.

The block also drives two service requests. The first is a level trigger that stays high while the fill count is at or above a programmable threshold. The second is an idle timeout: it fires when characters have waited unread, with no push and no pop, for a programmed number of character times. A fill word joins the receive count with a transmit count supplied from outside. A push that finds the buffer full is dropped and reported with a one-cycle overrun pulse.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset the buffer is empty, `level_word[7:0]` is 0, and `rd_word`, `rx_trig`, `rx_timeout` and `overrun` are all 0.
- R2: Characters leave in push order. After a pop of stored data, `rd_word` holds the character in bits 7:0, bit 8 = 0, the framing-error flag in bit 9 and the break flag in bit 10. The word is valid from the clock edge that samples `pop`.
- R3: A pop while the buffer is empty returns `rd_word` = 0x100: bit 8 set, data and flags zero. The fill count does not change.
- R4: `level_word[7:0]` is the receive fill count and `level_word[15:8]` mirrors `tx_fill`. Each accepted push without a pop raises the count by one.
- R5: `rx_trig` is high exactly while the fill count is at or above the threshold that `trig_code` selects. The thresholds are 1, 4, 8, 16, 32 and 48 for codes 0 to 5, and 48 for codes 6 and 7.
- R6: `tmo_code` 0 disables the timeout. Codes 1, 2 and 3 select 4, 8 and 16 character times, where one character time is CHAR_CLKS clock cycles (8 by default). `rx_timeout` rises when the idle count reaches that limit.
- R7: Every `push_valid` and every `pop` restarts the idle count. `rx_timeout` is never high while the buffer is empty.
- R8: A push into a full buffer with no pop in the same cycle is dropped. The stored contents do not change, and `overrun` is high for exactly the one cycle after that edge.
- R9: A push and a pop in the same cycle on a full buffer are both accepted. The count stays at the depth and the new character joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Receiver delivers a character this cycle |
| push_data | input | 8 | Received character |
| push_ferr | input | 1 | Framing error on this character |
| push_brk | input | 1 | Character is a break |
| pop | input | 1 | Register read of the data word |
| tx_fill | input | 8 | Transmit fill count, passed to the level word |
| trig_code | input | 3 | Receive trigger threshold select |
| tmo_code | input | 2 | Idle timeout select |
| rd_word | output | 11 | Tagged read word |
| level_word | output | 16 | Transmit and receive fill counts |
| rx_trig | output | 1 | Fill at or above threshold |
| rx_timeout | output | 1 | Unread data idle past the limit |
| overrun | output | 1 | One-cycle pulse on a dropped push |

## Verification
The assertions take for granted that every input is a defined 0 or 1 at each clock edge. They also assume `trig_code` and `tmo_code` hold still around the cycles where a property relates them to the outputs. The bench drives all inputs on the falling edge, so they are stable at the rising edge. It changes the codes only while it is not waiting on a timeout window. It never pushes and pops together except in the deliberate full-buffer case.

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DEPTH     = 64,
  parameter int DW        = 8,
  parameter int LVL_W     = 8,
  parameter int CHAR_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DW-1:0]     push_data,
  input  logic              push_ferr,
  input  logic              push_brk,
  input  logic              pop,
  input  logic [LVL_W-1:0]  tx_fill,
  input  logic [2:0]        trig_code,
  input  logic [1:0]        tmo_code,
  output logic [DW+2:0]     rd_word,
  output logic [2*LVL_W-1:0] level_word,
  output logic              rx_trig,
  output logic              rx_timeout,
  output logic              overrun
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int EW      = DW + 2;
  localparam int TMO_MAX = 16 * CHAR_CLKS;
  localparam int TW      = $clog2(TMO_MAX + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, trig_thr;
  logic [TW-1:0] idle_cnt, idle_lim;

  wire is_full  = (count == CW'(DEPTH));
  wire is_empty = (count == '0);
  wire do_pop   = pop && !is_empty;
  wire do_push  = push_valid && (!is_full || do_pop);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= {push_brk, push_ferr, push_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_word <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop)
        rd_word <= do_pop ? {mem[rd_ptr][EW-1:DW], 1'b0, mem[rd_ptr][DW-1:0]}
                          : {2'b00, 1'b1, {DW{1'b0}}};
      overrun <= push_valid && is_full && !pop;
    end
  end

  always_comb begin
    case (trig_code)
      3'd0:    trig_thr = CW'(1);
      3'd1:    trig_thr = CW'(4);
      3'd2:    trig_thr = CW'(8);
      3'd3:    trig_thr = CW'(16);
      3'd4:    trig_thr = CW'(32);
      default: trig_thr = CW'(48);
    endcase
  end

  always_comb begin
    case (tmo_code)
      2'd1:    idle_lim = TW'(4 * CHAR_CLKS);
      2'd2:    idle_lim = TW'(8 * CHAR_CLKS);
      default: idle_lim = TW'(16 * CHAR_CLKS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || push_valid || pop || is_empty) idle_cnt <= '0;
    else if (idle_cnt != TW'(TMO_MAX))           idle_cnt <= idle_cnt + 1'b1;
  end

  assign rx_trig    = (count >= trig_thr);
  assign rx_timeout = (tmo_code != 2'd0) && !is_empty && (idle_cnt >= idle_lim);
  assign level_word = {tx_fill, LVL_W'(count)};
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int LVL_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               push_valid,
  input logic               pop,
  input logic [2:0]         trig_code,
  input logic [DW+2:0]      rd_word,
  input logic [2*LVL_W-1:0] level_word,
  input logic               rx_trig,
  input logic               rx_timeout,
  input logic               overrun
);
  wire [LVL_W-1:0] lvl = level_word[LVL_W-1:0];

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LVL_W'(DEPTH));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !pop && lvl == LVL_W'(DEPTH)) |=> overrun);

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && lvl == '0) |=> (rd_word == {2'b00, 1'b1, {DW{1'b0}}}));

  // R7
  timeout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> (lvl != '0));

  // R4
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !pop && lvl < LVL_W'(DEPTH)) |=> (lvl == $past(lvl) + 1'b1));

  // R5
  trig_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_code == 3'd0 && lvl != '0) |-> rx_trig);
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop(pop),
  .trig_code(trig_code), .rd_word(rd_word), .level_word(level_word),
  .rx_trig(rx_trig), .rx_timeout(rx_timeout), .overrun(overrun)
);

// File: tb/rx_tag_fifo_bench.sv
module rx_tag_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 0, push_ferr = 0, push_brk = 0, pop = 0;
  logic [7:0] push_data = '0, tx_fill = '0;
  logic [2:0] trig_code = '0;
  logic [1:0] tmo_code = '0;
  logic [10:0] rd_word;
  logic [15:0] level_word;
  logic rx_trig, rx_timeout, overrun;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_tag_fifo u_rx_tag_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_ferr(push_ferr), .push_brk(push_brk), .pop(pop), .tx_fill(tx_fill),
    .trig_code(trig_code), .tmo_code(tmo_code), .rd_word(rd_word),
    .level_word(level_word), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic f, input logic b);
    @(negedge clk);
    push_valid = 1; push_data = d; push_ferr = f; push_brk = b;
    @(negedge clk);
    push_valid = 0; push_ferr = 0; push_brk = 0;
  endtask

  task automatic pop_one();
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
  endtask

  task automatic test_reset();
    chk(level_word[7:0] == 0, "R1 level", level_word[7:0], 0);
    chk(rd_word == 0, "R1 rd_word", rd_word, 0);
    chk({rx_trig, rx_timeout, overrun} == 0, "R1 flags", {rx_trig, rx_timeout, overrun}, 0);
  endtask

  task automatic test_order();
    push(8'h41, 0, 0); push(8'h42, 1, 0); push(8'h00, 0, 1);
    chk(level_word[7:0] == 3, "R4 count", level_word[7:0], 3);
    pop_one(); chk(rd_word == 11'h041, "R2 plain", rd_word, 11'h041);
    pop_one(); chk(rd_word == 11'h242, "R2 ferr", rd_word, 11'h242);
    pop_one(); chk(rd_word == 11'h400, "R2 break", rd_word, 11'h400);
  endtask

  task automatic test_empty_pop();
    pop_one();
    chk(rd_word == 11'h100, "R3 word", rd_word, 11'h100);
    chk(level_word[7:0] == 0, "R3 level", level_word[7:0], 0);
  endtask

  task automatic test_level();
    tx_fill = 8'h5A;
    push(8'h10, 0, 0); push(8'h11, 0, 0);
    chk(level_word == 16'h5A02, "R4 word", level_word, 16'h5A02);
    pop_one(); pop_one();
    tx_fill = 8'h00;
  endtask

  task automatic test_trigger();
    for (int lv = 0; lv < 50; lv++) begin
      for (int c = 0; c < 8; c++) begin
        int thr;
        thr = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : (c == 3) ? 16 : (c == 4) ? 32 : 48;
        trig_code = 3'(c);
        #1;
        chk(rx_trig == (lv >= thr), "R5 trig", rx_trig, (lv >= thr));
      end
      push(8'(lv), 0, 0);
    end
    trig_code = 0;
    for (int i = 0; i < 50; i++) pop_one();
    chk(level_word[7:0] == 0, "R5 drained", level_word[7:0], 0);
  endtask

  task automatic tmo_case(input logic [1:0] code, input int lim);
    tmo_code = code;
    push(8'h77, 0, 0);
    repeat (lim - 1) @(negedge clk);
    chk(rx_timeout == 0, "R6 before limit", rx_timeout, 0);
    @(negedge clk);
    chk(rx_timeout == 1, "R6 at limit", rx_timeout, 1);
    pop_one();
    chk(rx_timeout == 0, "R7 cleared by pop", rx_timeout, 0);
  endtask

  task automatic test_timeout();
    tmo_case(2'd1, 4 * CC);
    tmo_case(2'd2, 8 * CC);
    tmo_case(2'd3, 16 * CC);
    tmo_code = 2'd1;
    repeat (60) @(negedge clk);
    chk(rx_timeout == 0, "R7 empty", rx_timeout, 0);
    push(8'h01, 0, 0);
    repeat (20) @(negedge clk);
    push(8'h02, 0, 0);
    repeat (20) @(negedge clk);
    chk(rx_timeout == 0, "R7 restart", rx_timeout, 0);
    repeat (12) @(negedge clk);
    chk(rx_timeout == 1, "R7 after restart", rx_timeout, 1);
    tmo_code = 2'd0;
    #1;
    chk(rx_timeout == 0, "R6 disabled", rx_timeout, 0);
    repeat (200) @(negedge clk);
    chk(rx_timeout == 0, "R6 disabled long", rx_timeout, 0);
    pop_one(); pop_one();
  endtask

  task automatic test_overrun();
    for (int i = 0; i < 64; i++) push(8'(i), 0, 0);
    chk(level_word[7:0] == 64, "R8 full", level_word[7:0], 64);
    @(negedge clk); push_valid = 1; push_data = 8'hEE;
    @(negedge clk); push_valid = 0;
    chk(overrun == 1, "R8 pulse", overrun, 1);
    chk(level_word[7:0] == 64, "R8 level held", level_word[7:0], 64);
    @(negedge clk);
    chk(overrun == 0, "R8 one cycle", overrun, 0);
    pop = 1; push_valid = 1; push_data = 8'hAA;
    @(negedge clk); pop = 0; push_valid = 0;
    chk(rd_word == 11'h000, "R9 head", rd_word, 11'h000);
    chk(level_word[7:0] == 64, "R9 level", level_word[7:0], 64);
    chk(overrun == 0, "R9 no overrun", overrun, 0);
    for (int i = 1; i < 64; i++) begin
      pop_one();
      chk(rd_word == 11'(i), "R8 contents", rd_word, i);
    end
    pop_one();
    chk(rd_word == 11'h0AA, "R9 tail", rd_word, 11'h0AA);
    pop_one();
    chk(rd_word == 11'h100, "R3 after drain", rd_word, 11'h100);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_order();
    test_empty_pop();
    test_level();
    test_trigger();
    test_timeout();
    test_overrun();
    summary();
  end
endmodule